// File: doc/BRIEF.md
# Scheduled Traffic Gate List Sequencer

This block walks through a list of time slices held in an on-chip list memory and drives an 8-bit transmit gate mask to the transmit selector of one Ethernet port. Bit n of the mask, when high, lets a frame of priority n start. Each list entry pairs such a mask with a dwell length counted in wire-side clocks: 8 ns per clock at 1 Gbps, 40 ns at 100 Mbps and 400 ns at 10 Mbps. The mask only controls when a new frame may start. A frame already on the wire is never stopped, and that is the transmit selector's concern. An entry whose mask is all zero acts as a guard band, so the wire can drain before a critical slice begins.

The list memory holds 128 entries and has two modes. In one mode it is a single list of 128 entries. In the other it is two lists of 64 entries each, so software can write the next list into one half while the other half runs. A cycle-start pulse from the time base begins a pass at entry 0. The half that will run is sampled at that pulse. An entry with a zero count ends the list early. When the list ends, or when the pass moves past the last location of the running buffer, all gates close until the next pulse. A link-lost input throws the running list away. The gates stay closed until software writes the list again and starts a new cycle.

Top module: `tas_gate_sequencer`

## Requirements
- R1: After reset, gate_mask is 0. No cycle_start pulse is accepted until at least one entry has been written through the write port.
- R2: An accepted cycle_start loads entry 0 of the selected list, and its mask appears on gate_mask at the next clock. Each entry whose count C is 16 or more holds its mask for exactly C clocks. The next entry's mask then follows without a gap.
- R3: An entry whose count is 1 to 15 holds its mask for exactly 16 clocks.
- R4: An entry with count 0 ends the pass. gate_mask goes to 0 on the clock on which the previous entry's dwell expires, and it stays 0 until the next accepted cycle_start, which restarts the list at entry 0.
- R5: In two-list mode, when the dwell of local entry 63 expires, gate_mask goes to 0 and the sequencer waits for the next cycle_start.
- R6: In two-list mode (two_list_mode = 1), list h, local entry i, is stored at write address h*64 + i. buf_sel is sampled only when a cycle_start is accepted. A change of buf_sel during a pass does not alter that pass.
- R7: In single-list mode (two_list_mode = 0), the list is addresses 0 to 127 in order. The pass ends after entry 127, or earlier at a zero-count entry.
- R8: A cycle_start accepted during a pass abandons that pass and restarts at entry 0 of the list selected by buf_sel.
- R9: While enable is 0, gate_mask is 0 from the next clock onward and cycle_start pulses are ignored.
- R10: link_lost high forces gate_mask to 0 at the next clock. After that, cycle_start pulses are ignored until a write to the list memory is made while link_lost is low.
- R11: An entry with mask 0 and a nonzero count acts as a guard band. gate_mask is 0 for its dwell, and the following entry then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the list memory |
| wr_addr | input | 7 | Physical list memory address |
| wr_mask | input | 8 | Gate mask to store, bit n = priority n |
| wr_count | input | 14 | Dwell count to store, in wire clocks |
| two_list_mode | input | 1 | 1 = two lists of 64, 0 = one list of 128 |
| buf_sel | input | 1 | List to use in two-list mode, sampled at cycle start |
| enable | input | 1 | Allows the schedule to run |
| cycle_start | input | 1 | One-clock pulse that starts a schedule cycle |
| link_lost | input | 1 | Discards the running list and closes all gates |
| gate_mask | output | 8 | Registered gate-open mask, bit n = priority n |

## Verification
The sequencer is fed short directed lists that mix long dwells, sub-minimum counts and zero-mask guard entries. These separate exact dwell counting from the 16-clock floor, and a real guard slice from the end of a list. A full 64-entry half and a full 128-entry single list with no terminator show whether the pass stops at the buffer edge or wraps into the other half. Pulses during a pass, buf_sel changes during a pass, and enable or link_lost dropping in mid-list show that restarts and half switching happen only at an accepted cycle start. Seeded random lists in random halves are then compared cycle by cycle with a model of the dwell timeline computed in the bench.

// File: rtl/tas_gate_pkg.sv
`timescale 1ns/1ps
package tas_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tas_gate_ram.sv
`timescale 1ns/1ps
module tas_gate_ram #(
  parameter int MASK_W = 8,
  parameter int CNT_W  = 14,
  parameter int DEPTH  = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = MASK_W + CNT_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [AW-1:0]     rd_addr,
  output logic [MASK_W-1:0] rd_mask,
  output logic [CNT_W-1:0]  rd_count
);
  logic [ENT_W-1:0] mem_q [DEPTH];

  // storage array: no reset, written only through the port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= {wr_mask, wr_count};
    end
  end

  assign {rd_mask, rd_count} = mem_q[rd_addr];
endmodule

// File: rtl/tas_dwell_timer.sv
`timescale 1ns/1ps
module tas_dwell_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  output logic             expire
);
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             remain_en;

  always_comb begin
    remain_d  = remain_q;
    remain_en = 1'b0;
    if (clear) begin
      remain_d  = '0;
      remain_en = 1'b1;
    end else if (load) begin
      remain_d  = load_val;
      remain_en = 1'b1;
    end else if (remain_q != '0) begin
      remain_d  = remain_q - 1'b1;
      remain_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (remain_en) begin
      remain_q <= remain_d;
    end
  end

  assign expire = (remain_q == '0);
endmodule

// File: rtl/tas_gate_sequencer.sv
`timescale 1ns/1ps
module tas_gate_sequencer #(
  parameter int MASK_W    = 8,
  parameter int CNT_W     = 14,
  parameter int DEPTH     = 128,
  parameter int MIN_DWELL = 16,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              two_list_mode,
  input  logic              buf_sel,
  input  logic              enable,
  input  logic              cycle_start,
  input  logic              link_lost,
  output logic [MASK_W-1:0] gate_mask
);
  import tas_gate_pkg::*;

  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_DWELL);

  seq_state_e        state_q, state_d;
  logic [AW-1:0]     idx_q, idx_d;
  logic              half_q, half_d;
  logic              armed_q, armed_d;
  logic [MASK_W-1:0] mask_q, mask_d;

  logic              start_ok, step, past_end, end_hit, use_half;
  logic [AW:0]       nxt_local;
  logic [AW-1:0]     rd_addr;
  logic [MASK_W-1:0] rd_mask;
  logic [CNT_W-1:0]  rd_count;
  logic              tmr_load, tmr_clear, tmr_expire;
  logic [CNT_W-1:0]  tmr_load_val;

  tas_gate_ram #(.MASK_W(MASK_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_ram (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_mask  (wr_mask),
    .wr_count (wr_count),
    .rd_addr  (rd_addr),
    .rd_mask  (rd_mask),
    .rd_count (rd_count)
  );

  tas_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_load_val),
    .clear    (tmr_clear),
    .expire   (tmr_expire)
  );

  // look-ahead address of the entry that the next step would load
  assign start_ok  = cycle_start && enable && armed_q && !link_lost;
  assign step      = start_ok || (state_q == ST_RUN && tmr_expire);
  assign use_half  = start_ok ? buf_sel : half_q;
  assign nxt_local = start_ok ? '0 : ({1'b0, idx_q} + 1'b1);
  assign past_end  = two_list_mode ? (nxt_local[AW] | nxt_local[AW-1]) : nxt_local[AW];
  assign rd_addr   = two_list_mode ? {use_half, nxt_local[AW-2:0]} : nxt_local[AW-1:0];
  assign end_hit   = past_end || (rd_count == '0);

  // dwell floor: short counts stretched to the minimum slice
  assign tmr_load_val = (rd_count < MIN_C) ? (MIN_C - 1'b1) : (rd_count - 1'b1);

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    half_d    = half_q;
    mask_d    = mask_q;
    armed_d   = armed_q;
    tmr_load  = 1'b0;
    tmr_clear = 1'b0;

    if (link_lost) begin
      armed_d = 1'b0;
    end else if (wr_en) begin
      armed_d = 1'b1;
    end

    if (link_lost || !enable) begin
      state_d   = ST_IDLE;
      mask_d    = '0;
      tmr_clear = 1'b1;
    end else if (step) begin
      half_d = use_half;
      if (end_hit) begin
        state_d   = ST_WAIT;
        mask_d    = '0;
        tmr_clear = 1'b1;
      end else begin
        state_d  = ST_RUN;
        idx_d    = nxt_local[AW-1:0];
        mask_d   = rd_mask;
        tmr_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      half_q  <= 1'b0;
      mask_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      half_q  <= half_d;
      mask_q  <= mask_d;
      armed_q <= armed_d;
    end
  end

  assign gate_mask = mask_q;
endmodule

// File: rtl/tas_gate_sequencer_chk.sv
`timescale 1ns/1ps
module tas_gate_sequencer_chk #(
  parameter int MASK_W    = 8,
  parameter int CNT_W     = 14,
  parameter int MIN_DWELL = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic                     link_lost,
  input logic [MASK_W-1:0]        gate_mask,
  input tas_gate_pkg::seq_state_e state,
  input logic                     start_ok,
  input logic                     half,
  input logic                     load,
  input logic [CNT_W-1:0]         load_val,
  input logic                     expire
);
  import tas_gate_pkg::*;

  localparam logic [CNT_W-1:0] FLOOR_C = CNT_W'(MIN_DWELL - 1);

  AST_CLOSE_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    link_lost |=> gate_mask == '0); // R10

  AST_STOPPED_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_RUN |-> gate_mask == '0); // R4

  AST_DWELL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val >= FLOOR_C); // R3

  AST_HOLD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !expire && !start_ok && !link_lost && enable) |=> $stable(gate_mask)); // R2

  AST_HALF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && !start_ok) |=> $stable(half)); // R6

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_IDLE); // R9
endmodule

bind tas_gate_sequencer tas_gate_sequencer_chk #(
  .MASK_W(MASK_W), .CNT_W(CNT_W), .MIN_DWELL(MIN_DWELL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .link_lost (link_lost),
  .gate_mask (gate_mask),
  .state     (state_q),
  .start_ok  (start_ok),
  .half      (half_q),
  .load      (tmr_load),
  .load_val  (tmr_load_val),
  .expire    (tmr_expire)
);

// File: tb/tb_tas_gate_sequencer.sv
`timescale 1ns/1ps
module tb_tas_gate_sequencer;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [6:0]  wr_addr;
  logic [7:0]  wr_mask;
  logic [13:0] wr_count;
  logic        two_list_mode;
  logic        buf_sel;
  logic        enable;
  logic        cycle_start;
  logic        link_lost;
  logic [7:0]  gate_mask;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0]  m_mask [128];
  logic [13:0] m_cnt  [128];
  int          exp_two;
  int          exp_half;

  tas_gate_sequencer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_count(wr_count), .two_list_mode(two_list_mode),
    .buf_sel(buf_sel), .enable(enable), .cycle_start(cycle_start),
    .link_lost(link_lost), .gate_mask(gate_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // expected mask k clocks after the start-accepting edge (k = 0 first)
  function automatic logic [7:0] model(int k);
    int t;
    int e;
    int last;
    int base;
    t    = 0;
    last = (exp_two != 0) ? 63 : 127;
    base = (exp_two != 0) ? exp_half * 64 : 0;
    for (int i = 0; i <= last; i++) begin
      if (m_cnt[base + i] == 14'd0) return 8'h00;
      e = (m_cnt[base + i] < 14'd16) ? 16 : int'(m_cnt[base + i]);
      if (k < t + e) return m_mask[base + i];
      t = t + e;
    end
    return 8'h00;
  endfunction

  function automatic int list_len();
    int t;
    int last;
    int base;
    t    = 0;
    last = (exp_two != 0) ? 63 : 127;
    base = (exp_two != 0) ? exp_half * 64 : 0;
    for (int i = 0; i <= last; i++) begin
      if (m_cnt[base + i] == 14'd0) return t;
      t = t + ((m_cnt[base + i] < 14'd16) ? 16 : int'(m_cnt[base + i]));
    end
    return t;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, int k);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at step %0d: actual %h expected %h", req, k, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] m, logic [13:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_mask = m; wr_count = c;
    m_mask[a] = m; m_cnt[a] = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the negedge where step k = 0 is visible
  task automatic pulse_start();
    @(negedge clk);
    cycle_start = 1'b1;
    @(negedge clk);
    cycle_start = 1'b0;
  endtask

  task automatic watch(int k0, int n, string req);
    for (int k = k0; k < k0 + n; k++) begin
      check(req, gate_mask, model(k), k);
      @(negedge clk);
    end
  endtask

  task automatic watch_closed(int n, string req);
    for (int k = 0; k < n; k++) begin
      check(req, gate_mask, 8'h00, k);
      @(negedge clk);
    end
  endtask

  task automatic rand_list(int half, int n);
    for (int i = 0; i < n; i++) begin
      wr(half * 64 + i, 8'($urandom), 14'(1 + ($urandom % 40)));
    end
    wr(half * 64 + n, 8'($urandom), 14'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_mask = '0; wr_count = '0;
    two_list_mode = 1'b1; buf_sel = 1'b0; enable = 1'b1;
    cycle_start = 1'b0; link_lost = 1'b0;
    exp_two = 1; exp_half = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: closed after reset, start ignored before any write
    check("R1 reset", gate_mask, 8'h00, 0);
    pulse_start();
    watch_closed(20, "R1 unarmed start");

    // R2 R3 R11 R4: directed list in half 0
    wr(0, 8'h81, 14'd20);
    wr(1, 8'h00, 14'd16);   // guard band R11
    wr(2, 8'h3C, 14'd5);    // floor R3
    wr(3, 8'hA5, 14'd17);
    wr(4, 8'hFF, 14'd0);    // terminator R4
    pulse_start();
    watch(0, list_len() + 30, "R2 R3 R11 R4 directed");
    pulse_start();
    watch(0, 30, "R4 restart at entry 0");

    // R8: restart during a pass
    pulse_start();
    watch(0, 12, "R8 before restart");
    pulse_start();
    watch(0, list_len() + 5, "R8 after restart");

    // R6: buf_sel change mid-pass has no effect; next start uses half 1
    rand_list(1, 5);
    buf_sel = 1'b0; exp_half = 0;
    pulse_start();
    watch(0, 6, "R6 half0 pass");
    buf_sel = 1'b1;
    watch(6, list_len() + 4, "R6 sel changed mid pass");
    exp_half = 1;
    pulse_start();
    watch(0, list_len() + 10, "R6 half1 pass");

    // R5: full half 0 without terminator stops at entry 63
    for (int i = 0; i < 64; i++) wr(i, 8'(i + 1), 14'd16);
    buf_sel = 1'b0; exp_half = 0;
    pulse_start();
    watch(0, 64 * 16 + 20, "R5 end of half");

    // R7: single list of 128
    for (int i = 0; i < 128; i++) wr(i, 8'($urandom), 14'(16 + ($urandom % 4)));
    two_list_mode = 1'b0; exp_two = 0;
    pulse_start();
    watch(0, list_len() + 20, "R7 single list");
    wr(100, 8'h5A, 14'd0);
    pulse_start();
    watch(0, list_len() + 20, "R7 single list early end");

    // R9: enable low closes gates and blocks starts
    pulse_start();
    watch(0, 10, "R9 running");
    enable = 1'b0;
    @(negedge clk);
    check("R9 disabled", gate_mask, 8'h00, 0);
    pulse_start();
    watch_closed(20, "R9 start ignored");
    enable = 1'b1;

    // R10: link lost
    two_list_mode = 1'b1; exp_two = 1; exp_half = 0;
    rand_list(0, 4);
    pulse_start();
    watch(0, 10, "R10 running");
    link_lost = 1'b1;
    @(negedge clk);
    link_lost = 1'b0;
    check("R10 closed on loss", gate_mask, 8'h00, 0);
    pulse_start();
    watch_closed(20, "R10 start ignored before rewrite");
    wr(0, m_mask[0], m_cnt[0]);
    pulse_start();
    watch(0, list_len() + 5, "R10 rearmed");

    // random lists, random halves (R2 R3 R6)
    for (int r = 0; r < 6; r++) begin
      int h;
      h = int'($urandom % 2);
      rand_list(h, 2 + int'($urandom % 6));
      buf_sel = h[0]; exp_half = h;
      pulse_start();
      watch(0, list_len() + 8, "R2 R3 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule